// File: doc/BRIEF.md
# Keypad Sequence Lock Controller

This block watches a small keypad with two keys, A and B, plus a line that is high whenever any key is down. It accepts the three-key code B, A, B. When the full code arrives, it gives a one-cycle release pulse. It also reports how many keys have been taken in the current attempt, as a 4-bit count for a decimal display. The key lines must already be synchronous to the clock. Each clock cycle with the any-key line high counts as one key.

The outputs depend only on the stored state. A wrong key does not end the attempt at once: the count still advances, so an observer cannot tell where the code went wrong. One exception exists. A wrong third key after two correct ones returns the lock to idle on that key. After a success, the lock goes back to idle on the following clock whatever the inputs are. The block has no data stream, so all pins are plain control and status lines.

Top module: `lock_seq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is idle, with `key_count` = 0 and `unlock` = 0.
- R2: A cycle with `key_any` = 0 is no key. It leaves `key_count` and `unlock` unchanged, whatever `key_a` and `key_b` are (outside the success state).
- R3: The sequence B, A, B raises `unlock` for exactly the cycle after the third key, with `key_count` = 3. Key B is `key_any,key_a,key_b` = 1,0,1 and key A is 1,1,0.
- R4: A correct first key shows `key_count` = 1. A correct second key shows `key_count` = 2.
- R5: A wrong first key still shows 1, then any second key shows 2, then any third key shows 0 with no unlock.
- R6: After a correct first key, a wrong second key shows 2. The next key then returns the lock to idle (count 0, no unlock).
- R7: After two correct keys, a wrong third key returns the lock to idle (count 0) with no unlock.
- R8: When `key_any` = 1, the codes 1,1,1 and 1,0,0 count as keys, but they are never the expected key.
- R9: Bits 3 and 2 of `key_count` are always 0. `unlock` is high only while `key_count` = 3.
- R10: In the cycle after `unlock` rises, the lock is idle (`unlock` = 0, `key_count` = 0), even if a key is held during the success cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_any | input | 1 | High while any key is pressed |
| key_a | input | 1 | Key A line |
| key_b | input | 1 | Key B line |
| unlock | output | 1 | One-cycle release pulse |
| key_count | output | 4 | Keys taken in the current attempt |

## Verification
The state updates on the rising edge where a key is seen. Both outputs are decoded from the state alone, so every result appears one clock after the key that causes it, and stays steady until the next edge.

The bench drives each key code at a falling edge and waits one rising edge. It then samples shortly after that edge and compares against a count-and-flag model of the attempt. The sweep covers every run of four codes from the full 3-bit input space, so success, no-key cycles and keys held through the success state are all covered.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'b000,
    ST_OK1   = 3'b010,
    ST_OK2   = 3'b100,
    ST_OPEN  = 3'b111,
    ST_MISS1 = 3'b001,
    ST_MISS2 = 3'b011
  } lock_state_e;

  typedef enum logic [1:0] {
    KEY_NONE  = 2'd0,
    KEY_IS_A  = 2'd1,
    KEY_IS_B  = 2'd2,
    KEY_OTHER = 2'd3
  } key_class_e;
endpackage

// File: rtl/lock_key_classify.sv
module lock_key_classify
  import lock_pkg::*;
(
  input  logic       key_any,
  input  logic       key_a,
  input  logic       key_b,
  output key_class_e key_cls
);
  always_comb begin
    if (!key_any)
      key_cls = KEY_NONE;
    else if (key_a && !key_b)
      key_cls = KEY_IS_A;
    else if (key_b && !key_a)
      key_cls = KEY_IS_B;
    else
      key_cls = KEY_OTHER;
  end
endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
  import lock_pkg::*;
(
  input  lock_state_e cur,
  input  key_class_e  key_cls,
  output lock_state_e nxt
);
  logic pressed;
  assign pressed = (key_cls != KEY_NONE);

  always_comb begin
    nxt = cur;
    case (cur)
      ST_IDLE: begin
        if (key_cls == KEY_IS_B)  nxt = ST_OK1;
        else if (pressed)         nxt = ST_MISS1;
      end
      ST_OK1: begin
        if (key_cls == KEY_IS_A)  nxt = ST_OK2;
        else if (pressed)         nxt = ST_MISS2;
      end
      ST_OK2: begin
        if (key_cls == KEY_IS_B)  nxt = ST_OPEN;
        else if (pressed)         nxt = ST_IDLE;
      end
      ST_OPEN:  nxt = ST_IDLE;
      ST_MISS1: if (pressed) nxt = ST_MISS2;
      ST_MISS2: if (pressed) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/lock_display.sv
module lock_display
  import lock_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  lock_state_e      cur,
  output logic [CNT_W-1:0] count,
  output logic             open_pulse
);
  always_comb begin
    open_pulse = 1'b0;
    case (cur)
      ST_OK1, ST_MISS1: count = CNT_W'(1);
      ST_OK2, ST_MISS2: count = CNT_W'(2);
      ST_OPEN: begin
        count      = CNT_W'(3);
        open_pulse = 1'b1;
      end
      default: count = '0;
    endcase
  end
endmodule

// File: rtl/lock_seq_ctrl.sv
module lock_seq_ctrl
  import lock_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_any,
  input  logic             key_a,
  input  logic             key_b,
  output logic             unlock,
  output logic [CNT_W-1:0] key_count
);
  key_class_e  key_cls;
  lock_state_e state_q;
  lock_state_e state_d;

  lock_key_classify u_cls (
    .key_any (key_any),
    .key_a   (key_a),
    .key_b   (key_b),
    .key_cls (key_cls)
  );

  lock_next_state u_nxt (
    .cur     (state_q),
    .key_cls (key_cls),
    .nxt     (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  lock_display #(.CNT_W(CNT_W)) u_disp (
    .cur        (state_q),
    .count      (key_count),
    .open_pulse (unlock)
  );
endmodule

// File: rtl/lock_seq_chk.sv
module lock_seq_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             key_any,
  input logic             key_a,
  input logic             key_b,
  input logic             unlock,
  input logic [CNT_W-1:0] key_count
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (key_count == '0 && !unlock));

  p_no_key_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!key_any && !unlock) |=> $stable(key_count) && !unlock);

  p_second_key_r4: assert property (@(posedge clk) disable iff (rst)
    (key_any && key_count == CNT_W'(1)) |=> key_count == CNT_W'(2));

  p_bad_third_r7: assert property (@(posedge clk) disable iff (rst)
    (key_any && key_count == CNT_W'(2) && !(key_b && !key_a))
      |=> (!unlock && key_count == '0));

  p_open_count_r9: assert property (@(posedge clk) disable iff (rst)
    unlock |-> key_count == CNT_W'(3));

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
    key_count[CNT_W-1:2] == '0);

  p_one_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    unlock |=> (!unlock && key_count == '0));
endmodule

bind lock_seq_ctrl lock_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .key_any   (key_any),
  .key_a     (key_a),
  .key_b     (key_b),
  .unlock    (unlock),
  .key_count (key_count)
);

// File: tb/tb_lock_seq_ctrl.sv
module tb_lock_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       key_any = 1'b0;
  logic       key_a = 1'b0;
  logic       key_b = 1'b0;
  logic       unlock;
  logic [3:0] key_count;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // bench model of the attempt
  int m_cnt = 0;
  bit m_ok = 1'b0;

  always #5 clk = ~clk;

  lock_seq_ctrl dut (
    .clk       (clk),
    .rst       (rst),
    .key_any   (key_any),
    .key_a     (key_a),
    .key_b     (key_b),
    .unlock    (unlock),
    .key_count (key_count)
  );

  task automatic check(string tag, logic [3:0] exp_cnt, logic exp_unl);
    total++;
    if (key_count !== exp_cnt || unlock !== exp_unl) begin
      bad++;
      $display("FAIL %s: count=%0d unlock=%0b expected count=%0d unlock=%0b",
               tag, key_count, unlock, exp_cnt, exp_unl);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; key_any = 1'b0; key_a = 1'b0; key_b = 1'b0;
    @(posedge clk); #1;
    m_cnt = 0; m_ok = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // apply one code for one cycle, update model, sample after the edge
  task automatic step(logic [2:0] code, string tag_in);
    string tag;
    bit is_a, is_b;
    tag = tag_in;
    is_a = (code == 3'b110);
    is_b = (code == 3'b101);
    @(negedge clk);
    {key_any, key_a, key_b} = code;
    if (m_cnt == 3) begin
      m_cnt = 0; m_ok = 1'b0;
      if (tag == "") tag = "R10";
    end else if (!code[2]) begin
      if (tag == "") tag = "R2";
    end else begin
      if (tag == "") tag = (code == 3'b111 || code == 3'b100) ? "R8" : "";
      case (m_cnt)
        0: begin m_cnt = 1; m_ok = is_b; end
        1: begin m_cnt = 2; m_ok = m_ok && is_a; end
        default: begin
          if (m_ok && is_b) begin
            m_cnt = 3;
            if (tag == "") tag = "R3";
          end else begin
            if (tag == "") tag = m_ok ? "R7" : "R5";
            m_cnt = 0;
          end
          m_ok = 1'b0;
        end
      endcase
      if (tag == "") tag = "R4";
    end
    @(posedge clk); #1;
    check(tag, 4'(m_cnt), m_cnt == 3);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(posedge clk); #1;
    check("R1", 4'd0, 1'b0);
    do_reset();

    // R4 and R3 directed
    step(3'b101, "R4"); step(3'b000, "R2"); step(3'b110, "R4");
    step(3'b011, "R2"); step(3'b101, "R3"); step(3'b101, "R10");
    // R5: wrong first key path
    step(3'b110, "R5"); step(3'b110, "R5"); step(3'b101, "R5");
    // R6: wrong second key after correct first
    step(3'b101, "R6"); step(3'b101, "R6"); step(3'b110, "R6");
    // R7 and R8
    step(3'b101, "R8"); step(3'b110, "R8"); step(3'b111, "R7");
    // R9: upper bits stay zero while count shows 3
    step(3'b101, "R9"); step(3'b110, "R9"); step(3'b101, "R9");
    total++;
    if (key_count[3:2] !== 2'b00) begin
      bad++;
      $display("FAIL R9: upper=%0b expected 0", key_count[3:2]);
    end
    step(3'b000, "R10");

    // sweep every run of four 3-bit codes
    for (int s = 0; s < 4096; s++) begin
      do_reset();
      for (int k = 0; k < 4; k++) begin
        step(3'((s >> (3 * k)) & 7), "");
      end
    end

    // R1 reset out of a non-idle state
    step(3'b101, "R4");
    do_reset();
    check("R1", 4'd0, 1'b0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule